// File: doc/BRIEF.md
# Single-Address I/O Port Decoder with Output Control Latch

This block watches the low byte of the CPU address bus together with the CPU's active-low read and write port strobes. When the address is all ones (0xFF), it produces an active-low input select for a port read and an active-low output select for a port write. Every other address leaves both selects high.

A four-bit control register captures the write data when the output select ends. This is the moment the select returns high, and the clock domain detects it synchronously. The register then holds its value until the next write. Its bits drive four controls: a pair of cassette recording levels, the cassette motor enable, and the display width select. The host sets and clears these controls with single port writes.

Top module: `cas_port_ctl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register clears. After that edge `tape_lvl` is 0, `motor_on` is 0 and `narrow_mode` is 0 (the 64-column display).
- R2: `out_sel_n` is low exactly when `out_n` is low and `port_addr` equals 0xFF. Every other address, including those that differ only in bit 0 or only in bit 7, keeps it high.
- R3: `in_sel_n` is low exactly when `in_n` is low and `port_addr` equals 0xFF.
- R4: When the two strobes are never low together, `in_sel_n` and `out_sel_n` are never low together.
- R5: Suppose `out_sel_n` is sampled low at one clock edge and high at the next. The value of `wdata` sampled at that second edge then appears on the outputs, and it stays there until the next such rise.
- R6: The captured bits map to the outputs as follows. Bit 0 drives `tape_lvl[0]`. Bit 1 drives `tape_lvl[1]`. Bit 2 drives `motor_on`, where 1 means the motor runs. Bit 3 drives `narrow_mode`, where 1 selects 32 columns.
- R7: A write strobe at any address other than 0xFF leaves all four outputs unchanged.
- R8: A read strobe at 0xFF leaves all four outputs unchanged.
- R9: The outputs do not change while `out_sel_n` is held low, even if `wdata` changes during that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_addr | input | 8 | Low byte of the CPU address bus |
| in_n | input | 1 | Active-low CPU port read strobe |
| out_n | input | 1 | Active-low CPU port write strobe |
| wdata | input | 4 | CPU data bits 0 to 3 |
| in_sel_n | output | 1 | Active-low decoded port read select |
| out_sel_n | output | 1 | Active-low decoded port write select |
| tape_lvl | output | 2 | Latched cassette recording levels |
| motor_on | output | 1 | Latched cassette motor enable |
| narrow_mode | output | 1 | Latched display width select (1 = 32 columns) |

## Verification
The decoder is swept over all 256 addresses under three strobe settings: read only, write only, and no strobe. This sweep separates an exact 8-bit compare from one that drops bit 0 or the top bit. All 16 data values are written to 0xFF, and each value is checked on its own output bit. This catches swapped or stuck field wiring. Three further cases are interleaved with those writes: writes carrying complemented data to addresses one bit away from 0xFF, reads of 0xFF, and changes to the data while the strobe is still held low. Together they show whether the register loads only on the trailing edge of a decoded write.

// File: rtl/cas_port_pkg.sv
`timescale 1ns/1ps
// Shared constants and the control register layout for the port block.
package cas_port_pkg;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 4;
    localparam logic [ADDR_W-1:0] PORT_ADDR = 8'hFF;

    // Bit positions inside the captured control word.
    localparam int BIT_TAPE0  = 0;
    localparam int BIT_TAPE1  = 1;
    localparam int BIT_MOTOR  = 2;
    localparam int BIT_NARROW = 3;
endpackage

// File: rtl/cas_port_match.sv
`timescale 1ns/1ps
// Address match for one port. The compare is split into a bit-0 term and
// a term for the upper bits, and a low select needs both terms to hit.
// Assumes the address is stable for as long as a strobe is active.
module cas_port_match #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] PORT = '1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_n_o
);
    logic lo_miss;
    logic hi_miss;

    // Bit-0 term: misses when bit 0 differs from the port address.
    always_comb lo_miss = addr_i[0] ^ PORT[0];

    // Upper term: misses when any upper bit differs.
    always_comb hi_miss = |(addr_i[ADDR_W-1:1] ^ PORT[ADDR_W-1:1]);

    // Combined active-low hit.
    always_comb hit_n_o = lo_miss | hi_miss;
endmodule

// File: rtl/cas_port_gate.sv
`timescale 1ns/1ps
// Combines the active-low port hit with the active-low read and write
// strobes. Assumes the CPU never drives both strobes low at once.
module cas_port_gate (
    input  logic hit_n_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    output logic rd_sel_n_o,
    output logic wr_sel_n_o
);
    // Read select goes low only when the hit and the read strobe are both low.
    always_comb rd_sel_n_o = hit_n_i | rd_n_i;

    // Write select goes low only when the hit and the write strobe are both low.
    always_comb wr_sel_n_o = hit_n_i | wr_n_i;
endmodule

// File: rtl/cas_port_latch.sv
`timescale 1ns/1ps
// Control register that loads on the trailing (low-to-high) edge of an
// active-low strobe, with the edge detected in the clock domain.
// Assumes the strobe and data meet setup to clk.
module cas_port_latch #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);
    logic strobe_q;
    logic load;

    // Remember the previous strobe level; reset to idle-high.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_n_i;
    end

    // Trailing edge of the strobe: it was low and is now high.
    always_comb load = ~strobe_q & strobe_n_i;

    // Load the data on the trailing edge and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (load) q_o <= d_i;
    end
endmodule

// File: rtl/cas_port_ctl.sv
`timescale 1ns/1ps
// Single I/O port at address 0xFF. It decodes the read and write selects
// and drives cassette and display controls from a register loaded on the
// trailing edge of the write select. Assumes in_n and out_n are never
// low together.
module cas_port_ctl
    import cas_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic              in_n,
    input  logic              out_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              in_sel_n,
    output logic              out_sel_n,
    output logic [1:0]        tape_lvl,
    output logic              motor_on,
    output logic              narrow_mode
);
    logic              hit_n;
    logic [DATA_W-1:0] ctl_q;

    cas_port_match #(.ADDR_W(ADDR_W), .PORT(PORT_ADDR)) u_match (
        .addr_i  (port_addr),
        .hit_n_o (hit_n)
    );

    cas_port_gate u_gate (
        .hit_n_i    (hit_n),
        .rd_n_i     (in_n),
        .wr_n_i     (out_n),
        .rd_sel_n_o (in_sel_n),
        .wr_sel_n_o (out_sel_n)
    );

    cas_port_latch #(.DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (out_sel_n),
        .d_i        (wdata),
        .q_o        (ctl_q)
    );

    // Map the register fields onto the named outputs.
    always_comb begin
        tape_lvl[0] = ctl_q[BIT_TAPE0];
        tape_lvl[1] = ctl_q[BIT_TAPE1];
        motor_on    = ctl_q[BIT_MOTOR];
        narrow_mode = ctl_q[BIT_NARROW];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> ({narrow_mode, motor_on, tape_lvl} == 4'b0000));

    // R2
    foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_addr != PORT_ADDR) |-> (out_sel_n && in_sel_n));

    // R4
    sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!in_sel_n && !out_sel_n));

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(out_sel_n)) |=>
            ({narrow_mode, motor_on, tape_lvl} == $past(wdata)));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(out_sel_n) |=> $stable({narrow_mode, motor_on, tape_lvl}));
endmodule

// File: tb/cas_port_ctl_tb.sv
`timescale 1ns/1ps
module cas_port_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] port_addr = 8'h00;
    logic       in_n = 1'b1;
    logic       out_n = 1'b1;
    logic [3:0] wdata = 4'h0;
    logic       in_sel_n, out_sel_n, motor_on, narrow_mode;
    logic [1:0] tape_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    cas_port_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .port_addr(port_addr), .in_n(in_n),
        .out_n(out_n), .wdata(wdata), .in_sel_n(in_sel_n),
        .out_sel_n(out_sel_n), .tape_lvl(tape_lvl), .motor_on(motor_on),
        .narrow_mode(narrow_mode)
    );

    function automatic logic [3:0] outs();
        return {narrow_mode, motor_on, tape_lvl[1], tape_lvl[0]};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Full write cycle; checks the hold while the strobe is low (R9).
    task automatic do_write(logic [7:0] a, logic [3:0] d, logic [3:0] held);
        @(negedge clk);
        port_addr = a; wdata = d; out_n = 1'b0;
        @(negedge clk);
        wdata = ~d;
        @(negedge clk);
        chk("R9 hold while strobe low", {4'h0, outs()}, {4'h0, held});
        wdata = d; out_n = 1'b1;
        @(negedge clk);
        wdata = 4'h0;
        @(negedge clk);
    endtask

    initial begin
        logic [3:0] cur;
        repeat (3) @(negedge clk);
        chk("R1 reset clear", {4'h0, outs()}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {4'h0, outs()}, 8'h00);

        // R2 R3: decode sweep over every address.
        for (int a = 0; a < 256; a++) begin
            port_addr = a[7:0];
            out_n = 1'b0; in_n = 1'b1; #0.5;
            chk("R2 write select", {7'h0, out_sel_n}, {7'h0, !(a == 255)});
            chk("R3 read idle",    {7'h0, in_sel_n},  8'h01);
            out_n = 1'b1; in_n = 1'b0; #0.5;
            chk("R3 read select",  {7'h0, in_sel_n},  {7'h0, !(a == 255)});
            chk("R4 exclusive",    {7'h0, out_sel_n}, 8'h01);
            in_n = 1'b1; #0.5;
            chk("R2 no strobe", {6'h0, in_sel_n, out_sel_n}, 8'h03);
        end
        @(negedge clk);
        chk("R2 sweep left register", {4'h0, outs()}, 8'h00);

        // R5 R6 R7 R8: every data value, with foreign writes and reads.
        cur = 4'h0;
        for (int v = 0; v < 16; v++) begin
            do_write(8'hFF, v[3:0], cur);
            cur = v[3:0];
            chk("R5 capture", {4'h0, outs()}, {4'h0, cur});
            chk("R6 tape0 bit0",  {7'h0, tape_lvl[0]}, {7'h0, cur[0]});
            chk("R6 tape1 bit1",  {7'h0, tape_lvl[1]}, {7'h0, cur[1]});
            chk("R6 motor bit2",  {7'h0, motor_on},    {7'h0, cur[2]});
            chk("R6 narrow bit3", {7'h0, narrow_mode}, {7'h0, cur[3]});
            do_write(8'hFE, ~cur, cur);
            chk("R7 addr FE ignored", {4'h0, outs()}, {4'h0, cur});
            do_write(8'h7F, ~cur, cur);
            chk("R7 addr 7F ignored", {4'h0, outs()}, {4'h0, cur});
            do_write(8'h00, ~cur, cur);
            chk("R7 addr 00 ignored", {4'h0, outs()}, {4'h0, cur});
            @(negedge clk);
            port_addr = 8'hFF; wdata = ~cur; in_n = 1'b0;
            repeat (2) @(negedge clk);
            in_n = 1'b1;
            repeat (2) @(negedge clk);
            chk("R8 read ignored", {4'h0, outs()}, {4'h0, cur});
        end

        // R1: reset clears a non-zero register.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", {4'h0, outs()}, 8'h00);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule